// File: doc/BRIEF.md
# Lockable Pin Control Register Bank

This block keeps one configuration word per pin for a 32-pin port and sits on a simple memory-mapped bus with single-cycle writes and combinational read data. Each word holds a function-select field, pull enable and pull direction, an input filter enable, an interrupt configuration field and a lock bit. Two write-only broadcast registers each copy one 16-bit lower-half value into any subset of sixteen pin words in a single write. Pins whose lock bit is set are skipped, and the interrupt field of every targeted pin is left as it was.

From each stored word and the live output-enable request of its pin, the block drives that pin's pad controls: input buffer enable, gated output enable, effective pull enable, pull direction and filter enable. It also drives the interrupt configuration seen by the detection logic, which is gated by the port enable. Once a pin's lock bit is set, its lower half holds its value until the next reset. Writes to a locked word finish like any other write and raise no error. Only reset clears the words. Deasserting the port enable leaves them unchanged.

Top module: `pinctl_bank`

## Requirements
- R1: After reset every pin word reads 0x00000000 and every pad control output (input buffer, output enable, pull enable, pull direction, filter) and every interrupt output is 0.
- R2: A write to word address n (0 to 31) stores pull direction in bit 0, pull enable in bit 1, filter enable in bit 4, function select in bits 10:8, lock in bit 15 and interrupt configuration in bits 19:16. All other bits read back as 0.
- R3: While bit 15 of a pin word is 1, writes by any path leave bits 15:0 of that word unchanged, until reset.
- R4: A write to a locked pin word completes with bus_err low. bus_err is high only for an access to an address above 33.
- R5: A direct write updates the interrupt field in bits 19:16 even when the word is locked.
- R6: A write to address 32 treats bits 31:16 as a select mask for pins 0 to 15 (bit 16+k selects pin k). It loads bits 15:0 into each selected, unlocked pin and leaves interrupt fields and unselected pins unchanged.
- R7: A write to address 33 does the same for pins 16 to 31 (bit 16+k selects pin 16+k), and skips locked pins.
- R8: Reads of addresses 32 and 33 return 0.
- R9: With function select 0, the pin's input buffer, output enable, pull enable and filter enable outputs are all 0, whatever its output-enable request.
- R10: With function select 1 to 7, the input buffer enable is 1, the output enable follows the pin's request and the filter enable follows the stored bit.
- R11: The effective pull enable is 0 while the pin's output is enabled, even with the stored pull bit set. The stored bit still reads back as 1. Pull direction follows the stored bit.
- R12: A pin's interrupt output (bits 4n+3:4n) carries its stored field only while port_en is 1 and the pin is in a digital function. Deasserting port_en leaves every stored word unchanged.
- R13: Reset clears the lock bits, after which a previously locked word accepts writes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| port_en | input | 1 | Port enable; gates interrupt configuration outputs |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address: 0-31 pin words, 32-33 broadcast registers |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| bus_err | output | 1 | Access error, for addresses above 33 only |
| pad_oe_req | input | 32 | Output-enable request per pin from the functional logic |
| pad_ibe | output | 32 | Input buffer enable per pin |
| pad_obe | output | 32 | Gated output buffer enable per pin |
| pad_pe | output | 32 | Effective pull enable per pin |
| pad_ps | output | 32 | Pull direction per pin |
| pad_fe | output | 32 | Filter enable per pin |
| irq_cfg | output | 128 | Interrupt configuration per pin, 4 bits each |

## Verification
A single broadcast write can land on a mix of locked and unlocked pins while it carries a lock bit of its own. The skip decision then has to use the lock state from before that write, and the newly locked pins must still take the rest of the value. The bench sets this up by pre-locking one selected pin and by leaving one unselected pin with a known value. It then reads back every involved word and compares the lower half and the interrupt field against hand-computed values. A second same-cycle case is a change of a pin's output-enable request in the cycle its function select moves from 0 to digital. Here the bench checks the pull and output enables right after the write, before and after the request toggles.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;

  localparam int WORD_W   = 32;
  localparam int GLB_W    = 16;
  localparam int IRQ_W    = 4;
  localparam int MUX_W    = 3;

  localparam int B_PSEL   = 0;
  localparam int B_PEN    = 1;
  localparam int B_FILT   = 4;
  localparam int B_MUX_LO = 8;
  localparam int B_LOCK   = 15;
  localparam int B_IRQ_LO = 16;

  typedef struct packed {
    logic             lock;
    logic [MUX_W-1:0] mux;
    logic             filt;
    logic             pull_en;
    logic             pull_sel;
  } pin_low_t;

  typedef struct packed {
    logic [IRQ_W-1:0] irq;
    pin_low_t         low;
  } pin_cfg_t;

  function automatic pin_low_t low_from_half(input logic [GLB_W-1:0] h);
    pin_low_t l;
    l.lock     = h[B_LOCK];
    l.mux      = h[B_MUX_LO +: MUX_W];
    l.filt     = h[B_FILT];
    l.pull_en  = h[B_PEN];
    l.pull_sel = h[B_PSEL];
    return l;
  endfunction

  function automatic logic [WORD_W-1:0] cfg_to_word(input pin_cfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[B_LOCK]             = c.low.lock;
    w[B_MUX_LO +: MUX_W]  = c.low.mux;
    w[B_FILT]             = c.low.filt;
    w[B_PEN]              = c.low.pull_en;
    w[B_PSEL]             = c.low.pull_sel;
    w[B_IRQ_LO +: IRQ_W]  = c.irq;
    return w;
  endfunction

endpackage

// File: rtl/pinctl_rst_sync.sv
module pinctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pinctl_cell.sv
module pinctl_cell
  import pinctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_we,
  input  logic             glb_we,
  input  pin_low_t         dir_low,
  input  logic [IRQ_W-1:0] dir_irq,
  input  pin_low_t         glb_low,
  input  logic             oe_req,
  input  logic             port_en,
  output logic [WORD_W-1:0] rd_word,
  output logic             ibe,
  output logic             obe,
  output logic             pe,
  output logic             ps,
  output logic             fe,
  output logic [IRQ_W-1:0] irq_out
);

  pin_cfg_t cfg_q, cfg_d;
  logic     cfg_en;
  logic     digital;

  // next-state: lock guards the lower half on both paths, irq only direct
  always_comb begin
    cfg_d  = cfg_q;
    cfg_en = 1'b0;
    if (dir_we) begin
      cfg_en    = 1'b1;
      cfg_d.irq = dir_irq;
      if (!cfg_q.low.lock) cfg_d.low = dir_low;
    end else if (glb_we && !cfg_q.low.lock) begin
      cfg_en    = 1'b1;
      cfg_d.low = glb_low;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  // pad derivation
  assign digital = (cfg_q.low.mux != '0);
  assign ibe     = digital;
  assign obe     = digital & oe_req;
  assign pe      = digital & cfg_q.low.pull_en & ~oe_req;
  assign ps      = cfg_q.low.pull_sel;
  assign fe      = digital & cfg_q.low.filt;
  assign irq_out = (digital && port_en) ? cfg_q.irq : '0;
  assign rd_word = cfg_to_word(cfg_q);

  a_r3_lock_freezes_low: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word[B_LOCK] |=> $stable(rd_word[B_LOCK:0]));

  a_r6_irq_only_direct: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_we |=> $stable(rd_word[B_IRQ_LO +: IRQ_W]));

  a_r9_off_when_nondigital: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_word[B_MUX_LO +: MUX_W] == '0) |-> !(ibe || obe || pe || fe));

  a_r11_no_pull_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
    obe |-> !pe);

endmodule

// File: rtl/pinctl_bank.sv
module pinctl_bank
  import pinctl_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      port_en,
  input  logic                      bus_sel,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [WORD_W-1:0]         bus_wdata,
  output logic [WORD_W-1:0]         bus_rdata,
  output logic                      bus_err,
  input  logic [NUM_PINS-1:0]       pad_oe_req,
  output logic [NUM_PINS-1:0]       pad_ibe,
  output logic [NUM_PINS-1:0]       pad_obe,
  output logic [NUM_PINS-1:0]       pad_pe,
  output logic [NUM_PINS-1:0]       pad_ps,
  output logic [NUM_PINS-1:0]       pad_fe,
  output logic [NUM_PINS*IRQ_W-1:0] irq_cfg
);

  localparam int NUM_GLB  = (NUM_PINS + GLB_W - 1) / GLB_W;
  localparam int LAST_ADR = NUM_PINS + NUM_GLB - 1;
  localparam int IDX_W    = $clog2(NUM_PINS);

  logic                rst_i_n;
  logic                wr_stb;
  pin_low_t            wr_low;
  logic [IRQ_W-1:0]    wr_irq;
  logic [WORD_W-1:0]   rd_words [NUM_PINS];
  logic [NUM_PINS-1:0] dir_we, glb_we;
  logic                unused_wdata_bits;

  pinctl_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign wr_stb = bus_sel & bus_wr;
  assign wr_low = low_from_half(bus_wdata[GLB_W-1:0]);
  assign wr_irq = bus_wdata[B_IRQ_LO +: IRQ_W];
  assign unused_wdata_bits = ^{bus_wdata[7:5], bus_wdata[3:2], bus_wdata[14:11]};

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam logic [ADDR_W-1:0] PIN_ADR = ADDR_W'(i);
    localparam logic [ADDR_W-1:0] GLB_ADR = ADDR_W'(NUM_PINS + i / GLB_W);
    localparam int                SEL_BIT = GLB_W + (i % GLB_W);

    assign dir_we[i] = wr_stb && (bus_addr == PIN_ADR);
    assign glb_we[i] = wr_stb && (bus_addr == GLB_ADR) && bus_wdata[SEL_BIT];

    pinctl_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .dir_we  (dir_we[i]),
      .glb_we  (glb_we[i]),
      .dir_low (wr_low),
      .dir_irq (wr_irq),
      .glb_low (wr_low),
      .oe_req  (pad_oe_req[i]),
      .port_en (port_en),
      .rd_word (rd_words[i]),
      .ibe     (pad_ibe[i]),
      .obe     (pad_obe[i]),
      .pe      (pad_pe[i]),
      .ps      (pad_ps[i]),
      .fe      (pad_fe[i]),
      .irq_out (irq_cfg[i*IRQ_W +: IRQ_W])
    );
  end

  // read path: pin words only, broadcast registers read as zero
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr && (int'(bus_addr) < NUM_PINS))
      bus_rdata = rd_words[bus_addr[IDX_W-1:0]];
  end

  assign bus_err = bus_sel && (int'(bus_addr) > LAST_ADR);

  a_r4_err_only_unmapped: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_sel && int'(bus_addr) <= LAST_ADR) |-> !bus_err);

  a_r8_broadcast_reads_zero: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_sel && !bus_wr && int'(bus_addr) >= NUM_PINS) |-> (bus_rdata == '0));

  a_r6_one_target_direct: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0(dir_we));

endmodule

// File: tb/tb_pinctl_bank.sv
module tb_pinctl_bank;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         port_en;
  logic         bus_sel, bus_wr;
  logic [5:0]   bus_addr;
  logic [31:0]  bus_wdata, bus_rdata;
  logic         bus_err;
  logic [31:0]  pad_oe_req, pad_ibe, pad_obe, pad_pe, pad_ps, pad_fe;
  logic [127:0] irq_cfg;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  pinctl_bank dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .pad_oe_req(pad_oe_req), .pad_ibe(pad_ibe), .pad_obe(pad_obe),
    .pad_pe(pad_pe), .pad_ps(pad_ps), .pad_fe(pad_fe), .irq_cfg(irq_cfg)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // write with error sampled in the write cycle
  task automatic wr(input logic [5:0] a, input logic [31:0] d, output logic err);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    #1 err = bus_err;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 chk(req, 64'(bus_rdata), 64'(exp));
    bus_sel = 1'b0;
  endtask

  task automatic t_reset();
    logic e;
    rd_chk("R1 word0", 6'd0, 32'h0);
    rd_chk("R1 word31", 6'd31, 32'h0);
    chk("R1 pads", {pad_ibe | pad_obe | pad_pe | pad_ps | pad_fe, 32'h0}, 64'h0);
    chk("R1 irq", 64'(|irq_cfg), 64'h0);
    wr(6'd40, 32'h0, e);
    chk("R4 unmapped err", 64'(e), 64'h1);
  endtask

  task automatic t_direct();
    logic e;
    wr(6'd3, 32'hFFF0_FFFF, e);
    rd_chk("R2 layout", 6'd3, 32'h0000_8713);
    wr(6'd10, 32'h000F_0713, e);
    rd_chk("R2 fields", 6'd10, 32'h000F_0713);
  endtask

  task automatic t_lock();
    logic e;
    wr(6'd5, 32'h0000_8313, e);
    wr(6'd5, 32'h0000_0000, e);
    chk("R4 locked write no err", 64'(e), 64'h0);
    rd_chk("R3 locked low kept", 6'd5, 32'h0000_8313);
    wr(6'd5, 32'h0002_0000, e);
    rd_chk("R5 irq through lock", 6'd5, 32'h0002_8313);
  endtask

  task automatic t_global_lo();
    logic e;
    wr(6'd0, 32'h0003_0000, e);
    wr(6'd1, 32'h0000_8100, e);
    wr(6'd4, 32'h0000_0001, e);
    wr(6'd32, 32'h0007_8212, e);
    chk("R4 global no err", 64'(e), 64'h0);
    rd_chk("R6 pin0 loaded, irq kept", 6'd0, 32'h0003_8212);
    rd_chk("R6 pin1 locked skipped", 6'd1, 32'h0000_8100);
    rd_chk("R6 pin2 loaded", 6'd2, 32'h0000_8212);
    rd_chk("R6 pin4 unselected", 6'd4, 32'h0000_0001);
    wr(6'd32, 32'h0001_0000, e);
    rd_chk("R3 global blocked by lock", 6'd0, 32'h0003_8212);
  endtask

  task automatic t_global_hi();
    logic e;
    wr(6'd17, 32'h0000_8200, e);
    wr(6'd33, 32'h0003_0301, e);
    rd_chk("R7 pin16 loaded", 6'd16, 32'h0000_0301);
    rd_chk("R7 pin17 locked skipped", 6'd17, 32'h0000_8200);
    rd_chk("R7 pin0 untouched", 6'd0, 32'h0003_8212);
    rd_chk("R8 addr32 reads zero", 6'd32, 32'h0);
    rd_chk("R8 addr33 reads zero", 6'd33, 32'h0);
  endtask

  task automatic t_pads();
    logic e;
    pad_oe_req = 32'h0000_0040;
    wr(6'd6, 32'h0000_0013, e);
    #1;
    chk("R9 analog all off", {pad_ibe[6], pad_obe[6], pad_pe[6], pad_fe[6]}, 64'h0);
    wr(6'd6, 32'h0000_0113, e);
    #1;
    chk("R10 driving", {pad_ibe[6], pad_obe[6], pad_fe[6]}, 64'h7);
    chk("R11 pull off while driving", {pad_pe[6], pad_ps[6]}, 64'h1);
    pad_oe_req = 32'h0;
    #1;
    chk("R10/R11 released", {pad_ibe[6], pad_obe[6], pad_pe[6], pad_fe[6]}, 64'hB);
    rd_chk("R11 stored pull bit kept", 6'd6, 32'h0000_0113);
  endtask

  task automatic t_port_en();
    logic e;
    wr(6'd7, 32'h0005_0100, e);
    #1 chk("R12 irq visible", 64'(irq_cfg[31:28]), 64'h5);
    port_en = 1'b0;
    #1 chk("R12 irq gated", 64'(irq_cfg[31:28]), 64'h0);
    rd_chk("R12 retained", 6'd7, 32'h0005_0100);
    port_en = 1'b1;
    wr(6'd8, 32'h0009_0000, e);
    #1 chk("R12 nondigital irq off", 64'(irq_cfg[35:32]), 64'h0);
  endtask

  task automatic t_reset_clears();
    logic e;
    do_reset();
    rd_chk("R13 cleared", 6'd5, 32'h0);
    wr(6'd5, 32'h0000_0100, e);
    rd_chk("R13 unlocked after reset", 6'd5, 32'h0000_0100);
  endtask

  initial begin
    rst_n = 1'b0; port_en = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0; pad_oe_req = '0;
    do_reset();
    t_reset();
    t_direct();
    t_lock();
    t_global_lo();
    t_global_hi();
    t_pads();
    t_port_en();
    t_reset_clears();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule